// File: doc/BRIEF.md
# LED Blink Pattern Generator

This block makes one LED blink under software control. A base clock is divided by a selectable power of two into a tick. On each tick a 12-bit phase counter steps from zero up to a programmed period value and then wraps. The LED output is on while the phase count is below a programmed duty value. Software programs the block through four word registers: a control word, the period, the duty, and a 16-bit run-length count.

When the run-length option is on, the block counts completed periods. After the programmed number of them it switches itself off and sets a sticky completion flag. That flag drives an interrupt request unless a mask bit blocks it. Any write to the control word clears the flag.

A two-state controller governs the block. `ST_IDLE` holds the LED off. The transition *arm* (a control write with the enable bit set while idle) goes to `ST_RUN` and restarts the prescaler, the phase counter and the run-length counter. While in `ST_RUN`, the transition *rearm* (a control write with the enable bit set) stays in `ST_RUN` and restarts nothing. Two transitions return to `ST_IDLE`: *disarm* (a control write with the enable bit clear) and *expire* (the run-length counter runs out). *Expire* also sets the completion flag.

Top module: `led_blink_top`

## Requirements
- R1: After reset every register reads 0, `led_out` is 0 and `irq` is 0.
- R2: Registers are selected by `reg_addr[3:2]` (0 control, 1 period, 2 duty, 3 run length), and only when `reg_addr[1:0]` is 0. Period and duty keep 12 bits and read back with the upper bits zero. The run length keeps 16 bits.
- R3: Control word layout: bits 3:0 are the divider select, bit 4 is enable, bit 5 is the run-length option and bit 6 is the interrupt mask. A select value written above 13 is stored and applied as 13.
- R4: With select n, one tick occurs every 2^(13-n) base clock cycles, counted from the arming edge.
- R5: The LED is on exactly while the running phase count is below the duty value. A duty of 0 keeps it off, and a duty above the period keeps it on.
- R6: The phase count advances by one per tick and wraps from the period value to 0, so one period lasts period+1 ticks.
- R7: With the run-length option on and a count N of at least 1, the block returns to idle on the tick that completes the Nth period. The LED goes off and the enable bit reads back 0.
- R8: Expiry sets a sticky flag, and `irq` equals that flag while the mask bit is 0. With the mask set, `irq` stays 0.
- R9: Any control write clears the completion flag.
- R10: Arming from idle restarts all counters and reloads the run-length count. Rewriting the enable bit as 1 while running leaves the LED pattern uninterrupted.
- R11: A control write with the enable bit clear turns the LED off on the next cycle.
- R12: A run-length count of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| led_out | output | 1 | LED drive |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench uses the default parameters: a 13-step divider exponent, 12-bit phase and duty, and a 16-bit run length. Select values 13 and 12 give ticks every cycle and every second cycle, and a written 15 shows the saturation. Short periods of one to four ticks with run lengths of 0, 2 and 3 make expiry, masking, reload and rearm happen within a few dozen cycles, and every one of those cycles is compared.

// File: rtl/ledblk_pkg.sv
package ledblk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } blink_state_e;

    localparam logic [1:0] SLOT_CTRL   = 2'd0;
    localparam logic [1:0] SLOT_PERIOD = 2'd1;
    localparam logic [1:0] SLOT_DUTY   = 2'd2;
    localparam logic [1:0] SLOT_RUNLEN = 2'd3;

endpackage

// File: rtl/ledblk_prescale.sv
module ledblk_prescale #(
    parameter int MAX_SEL = 13,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;
    logic [SEL_W-1:0] shamt;

    // sel is saturated upstream, so the shift amount never goes negative
    always_comb begin
        shamt = SEL_W'(MAX_SEL) - sel;
        span  = (PRE_W+1)'(1) << shamt;
        limit = PRE_W'(span - (PRE_W+1)'(1));
    end

    assign tick = run && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= '0;
        end else if (run) begin
            pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
        end
    end

    // R4: two ticks in a row only with the fastest divider
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || limit == '0));

endmodule

// File: rtl/ledblk_phase.sv
module ledblk_phase #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] phase,
    output logic             wrap,
    output logic             led
);
    assign wrap = tick && (phase == period);
    assign led  = run && (phase < duty);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (tick) begin
            phase <= wrap ? '0 : phase + CNT_W'(1);
        end
    end

    // R6: the count never passes a steady period value
    a_r6_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(period) && $past(phase <= period)) |-> (phase <= period));

endmodule

// File: rtl/ledblk_runlen.sv
module ledblk_runlen #(
    parameter int STOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wrap,
    input  logic              opt_on,
    input  logic [STOP_W-1:0] reload,
    output logic              expire
);
    logic [STOP_W-1:0] remain;
    logic              last_one;

    // a loaded 0 counts as 1 (R12)
    assign last_one = (remain <= STOP_W'(1));
    assign expire   = opt_on && wrap && last_one;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (restart) begin
            remain <= reload;
        end else if (opt_on && wrap && !last_one) begin
            remain <= remain - STOP_W'(1);
        end
    end

    // R7: the remaining count only falls one period at a time
    a_r7_runlen_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && remain != $past(remain)) |-> (remain == $past(remain) - STOP_W'(1)));

endmodule

// File: rtl/ledblk_ctrl.sv
module ledblk_ctrl
    import ledblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic en_bit,
    input  logic expire,
    output logic run,
    output logic restart,
    output logic done_flag
);
    blink_state_e state, state_nx;
    logic         expire_take;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ctrl_wr && en_bit) state_nx = ST_RUN;   // arm
            ST_RUN: begin
                if (ctrl_wr && !en_bit)      state_nx = ST_IDLE; // disarm
                else if (!ctrl_wr && expire) state_nx = ST_IDLE; // expire
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        run         = (state == ST_RUN);
        restart     = (state == ST_IDLE) && ctrl_wr && en_bit;
        expire_take = (state == ST_RUN) && !ctrl_wr && expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           done_flag <= 1'b0;
        else if (expire_take) done_flag <= 1'b1;
        else if (ctrl_wr)     done_flag <= 1'b0;
    end

    // R8: the flag rises only on leaving the running state
    a_r8_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (state == ST_IDLE && $past(state) == ST_RUN));

    // R9: a control write always leaves the flag clear
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !done_flag);

endmodule

// File: rtl/led_blink_top.sv
module led_blink_top
    import ledblk_pkg::*;
#(
    parameter int MAX_SEL = 13,
    parameter int SEL_W   = 4,
    parameter int CNT_W   = 12,
    parameter int STOP_W  = 16,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              led_out,
    output logic              irq
);
    localparam int EN_BIT   = SEL_W;
    localparam int OPT_BIT  = SEL_W + 1;
    localparam int MASK_BIT = SEL_W + 2;
    localparam int CTRL_W   = SEL_W + 3;

    logic [1:0]        slot;
    logic              aligned;
    logic              ctrl_wr;
    logic [SEL_W-1:0]  sel_q, sel_in;
    logic              opt_q, mask_q;
    logic [CNT_W-1:0]  period_q, duty_q, phase;
    logic [STOP_W-1:0] runlen_q;
    logic              run, restart, done_flag, tick, wrap, expire, led_w;
    logic              unused_wdata_hi;

    assign slot            = reg_addr[3:2];
    assign aligned         = (reg_addr[1:0] == 2'b00);
    assign ctrl_wr         = reg_wr && aligned && (slot == SLOT_CTRL);
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];
    assign sel_in = (reg_wdata[SEL_W-1:0] > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL)
                                                             : reg_wdata[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            opt_q    <= 1'b0;
            mask_q   <= 1'b0;
            period_q <= '0;
            duty_q   <= '0;
            runlen_q <= '0;
        end else if (reg_wr && aligned) begin
            unique case (slot)
                SLOT_CTRL: begin
                    sel_q  <= sel_in;
                    opt_q  <= reg_wdata[OPT_BIT];
                    mask_q <= reg_wdata[MASK_BIT];
                end
                SLOT_PERIOD: period_q <= reg_wdata[CNT_W-1:0];
                SLOT_DUTY:   duty_q   <= reg_wdata[CNT_W-1:0];
                SLOT_RUNLEN: runlen_q <= reg_wdata[STOP_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            unique case (slot)
                SLOT_CTRL:   reg_rdata = DATA_W'({mask_q, opt_q, run, sel_q});
                SLOT_PERIOD: reg_rdata = DATA_W'(period_q);
                SLOT_DUTY:   reg_rdata = DATA_W'(duty_q);
                SLOT_RUNLEN: reg_rdata = DATA_W'(runlen_q);
                default:     reg_rdata = '0;
            endcase
        end
    end

    ledblk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .en_bit    (reg_wdata[EN_BIT]),
        .expire    (expire),
        .run       (run),
        .restart   (restart),
        .done_flag (done_flag)
    );

    ledblk_prescale #(.MAX_SEL(MAX_SEL), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .sel     (sel_q),
        .tick    (tick)
    );

    ledblk_phase #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .tick    (tick),
        .period  (period_q),
        .duty    (duty_q),
        .phase   (phase),
        .wrap    (wrap),
        .led     (led_w)
    );

    ledblk_runlen #(.STOP_W(STOP_W)) u_runlen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .wrap    (wrap),
        .opt_on  (opt_q),
        .reload  (runlen_q),
        .expire  (expire)
    );

    assign led_out = led_w;
    assign irq     = done_flag && !mask_q;

    // R11: no light while idle
    a_r11_dark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !led_out);

    // R10: every arming starts at phase zero
    a_r10_arm_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (phase == '0));

    // R8: a pending request only exists while halted
    a_r8_irq_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !run);

    // R3: the stored select stays in range
    a_r3_sel_capped: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q <= SEL_W'(MAX_SEL));

endmodule

// File: tb/tb_led_blink_top.sv
module tb_led_blink_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        led_out, irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic  led;
        logic  irq;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    led_blink_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_out(led_out), .irq(irq)
    );

    // monitor: one expected item per cycle
    always @(negedge clk) begin : mon
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (led_out !== e.led || irq !== e.irq) begin
                failures++;
                $display("FAIL %s: led/irq actual %b/%b expected %b/%b",
                         e.tag, led_out, irq, e.led, e.irq);
            end
        end
    end

    function automatic logic [15:0] ctl(int sel, bit en, bit opt, bit msk);
        return {9'd0, msk, opt, en, 4'(sel)};
    endfunction

    task automatic do_write(logic [1:0] slot, logic [15:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = {slot, 2'b00};
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(logic [3:0] addr, logic [15:0] exp, string tag);
        @(negedge clk);
        reg_addr = addr;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s: rdata actual %h expected %h", tag, reg_rdata, exp);
        end
    endtask

    // driver: model of the LED pattern, cycle k after the arming edge
    task automatic push_run(int k0, int n, int per, int duty, int div, int runlen,
                            bit opt, bit msk, string tag);
        int stop_at;
        stop_at = ((runlen == 0) ? 1 : runlen) * (per + 1) * div;
        for (int k = k0; k < k0 + n; k++) begin
            exp_t e;
            bit halted;
            halted = opt && (k >= stop_at);
            e.led  = !halted && (((k / div) % (per + 1)) < duty);
            e.irq  = halted && !msk;
            e.tag  = tag;
            q.push_back(e);
        end
        wait (q.size() == 0);
    endtask

    task automatic push_dark(int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.led = 1'b0;
            e.irq = 1'b0;
            e.tag = tag;
            q.push_back(e);
        end
        wait (q.size() == 0);
    endtask

    task automatic disarm(string tag);
        do_write(2'd0, ctl(13, 0, 0, 0));
        push_dark(3, tag);
    endtask

    task automatic summary;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        checks++;
        if (led_out !== 1'b0 || irq !== 1'b0) begin
            failures++;
            $display("FAIL R1: led/irq actual %b/%b expected 0/0", led_out, irq);
        end
        for (int s = 0; s < 4; s++) rd_check(4'(s * 4), 16'h0000, "R1 reset register");

        // R2: widths and decode
        do_write(2'd1, 16'hFFFF);
        rd_check(4'h4, 16'h0FFF, "R2 period width");
        do_write(2'd2, 16'h1234);
        rd_check(4'h8, 16'h0234, "R2 duty width");
        do_write(2'd3, 16'hBEEF);
        rd_check(4'hC, 16'hBEEF, "R2 run length width");
        rd_check(4'h5, 16'h0000, "R2 unaligned read");

        // R3: select saturation in the stored field
        do_write(2'd0, ctl(15, 0, 0, 1));
        rd_check(4'h0, 16'h004D, "R3 select capped");

        // R5 R6: basic pattern, period 4, duty 2
        do_write(2'd1, 16'd4);
        do_write(2'd2, 16'd2);
        do_write(2'd0, ctl(13, 1, 0, 0));
        push_run(0, 15, 4, 2, 1, 0, 0, 0, "R5 R6 pattern");
        rd_check(4'h0, 16'h001D, "R3 enable reads back");
        disarm("R11 disarm");
        rd_check(4'h0, 16'h000D, "R11 enable cleared");

        // R4: divide by two
        do_write(2'd1, 16'd2);
        do_write(2'd2, 16'd1);
        do_write(2'd0, ctl(12, 1, 0, 0));
        push_run(0, 16, 2, 1, 2, 0, 0, 0, "R4 divide by two");
        disarm("R11 disarm");

        // R3: written 15 runs as 13
        do_write(2'd0, ctl(15, 1, 0, 0));
        push_run(0, 8, 2, 1, 1, 0, 0, 0, "R3 saturated divider");
        disarm("R11 disarm");

        // R5: duty above period and duty zero
        do_write(2'd2, 16'd5);
        do_write(2'd0, ctl(13, 1, 0, 0));
        push_run(0, 6, 2, 5, 1, 0, 0, 0, "R5 duty above period");
        disarm("R11 disarm");
        do_write(2'd2, 16'd0);
        do_write(2'd0, ctl(13, 1, 0, 0));
        push_run(0, 6, 2, 0, 1, 0, 0, 0, "R5 zero duty");
        disarm("R11 disarm");

        // R10: rearm while running keeps counting
        do_write(2'd1, 16'd3);
        do_write(2'd2, 16'd2);
        do_write(2'd0, ctl(13, 1, 0, 0));
        push_run(0, 6, 3, 2, 1, 0, 0, 0, "R10 before rearm");
        do_write(2'd0, ctl(13, 1, 0, 0));
        push_run(7, 8, 3, 2, 1, 0, 0, 0, "R10 after rearm");
        disarm("R11 disarm");

        // R7 R8: run length 3, unmasked
        do_write(2'd1, 16'd2);
        do_write(2'd2, 16'd1);
        do_write(2'd3, 16'd3);
        do_write(2'd0, ctl(13, 1, 1, 0));
        push_run(0, 14, 2, 1, 1, 3, 1, 0, "R7 R8 expiry");
        rd_check(4'h0, 16'h002D, "R7 enable cleared on expiry");

        // R10: arming again reloads the run length
        do_write(2'd0, ctl(13, 1, 1, 0));
        push_run(0, 14, 2, 1, 1, 3, 1, 0, "R10 reload");

        // R9: control write clears the flag
        do_write(2'd0, ctl(13, 0, 1, 0));
        push_dark(2, "R9 flag cleared");

        // R8: masked expiry
        do_write(2'd1, 16'd1);
        do_write(2'd3, 16'd2);
        do_write(2'd0, ctl(13, 1, 1, 1));
        push_run(0, 8, 1, 1, 1, 2, 1, 1, "R8 masked");
        rd_check(4'h0, 16'h006D, "R8 masked readback");
        do_write(2'd0, ctl(13, 0, 1, 0));
        push_dark(2, "R9 flag cleared");

        // R12: run length 0 acts as 1
        do_write(2'd1, 16'd3);
        do_write(2'd2, 16'd3);
        do_write(2'd3, 16'd0);
        do_write(2'd0, ctl(13, 1, 1, 0));
        push_run(0, 8, 3, 3, 1, 0, 1, 0, "R12 zero run length");
        do_write(2'd0, ctl(13, 0, 0, 0));
        push_dark(2, "R9 flag cleared");

        summary();
        $finish;
    end

endmodule